// File: doc/BRIEF.md
# Four-to-Two Row Compressor

This block takes four rows of partial product bits, all W bits wide and all at the same weight, and reduces them to two rows: a sum row and a carry row. Adding those two rows gives exactly the sum of the four inputs. The block has no clock and no state. It is built as one pass of a reduction tree for wide multipliers. Several such rows can be stacked, and a final carry-propagate adder, which lies outside this block, turns the two rows into a single product.

Each bit position holds one compressor cell. The cell takes five inputs: the four row bits and a side carry from the cell one bit lower. It gives three outputs: a sum bit, a carry bit and a side carry to the cell one bit higher. The side carry a cell sends upward depends only on three of its own row bits, so no carry runs the length of the row. The sum path crosses three XOR levels.

Top module: `cmp42_reduce`

## Requirements
- R1: `sum_o + carry_o`, taken as unsigned W+2 bit numbers, equals `row0_i + row1_i + row2_i + row3_i` for every input.
- R2: `carry_o[0]` is always 0.
- R3: `sum_o[W+1]` is always 0.
- R4: For each bit i below W, `sum_o[i]` is the parity of the four row bits at i together with the side carry entering cell i. The side carry entering cell 0 is 0.
- R5: The side carry leaving cell i is 1 exactly when at least two of `row0_i[i]`, `row1_i[i]` and `row2_i[i]` are 1. It does not depend on `row3_i` or on the side carry entering cell i. The side carry leaving the top cell appears at `sum_o[W]`.
- R6: For each bit i below W, `carry_o[i+1]` equals (n − `sum_o[i]`)/2 minus the side carry leaving cell i, where n is the count of ones among the five inputs of cell i.
- R7: When all four rows are all ones, both outputs equal 2^(W+1) − 2. For W = 16 that is 18'h1FFFE.
- R8: When all four rows are zero, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| row0_i | input | W | First partial product row |
| row1_i | input | W | Second partial product row |
| row2_i | input | W | Third partial product row |
| row3_i | input | W | Fourth partial product row |
| sum_o | output | W+2 | Sum row; bit W holds the side carry out of the top cell |
| carry_o | output | W+2 | Carry row, already shifted left by one bit |

## Verification
The assertions are checked whenever the inputs change. They check the five-to-three count identity in every cell, the bounds on the side carry, the zero bits at the two ends of the output rows, and that the whole row keeps the total unchanged.

Only the bench scenarios check the exact bit placement in both rows. That covers the parity of each sum bit, the split between the carry bit and the side carry, and the fixed patterns for all-ones and all-zero inputs. These checks compare the outputs against a separate per-bit counting model.

// File: rtl/cmp42_pkg.sv
package cmp42_pkg;

  // Returns 1 when at least two of the three bits are set.
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // Selects one of two bits with a select bit.
  function automatic logic pick(input logic sel, input logic when1, input logic when0);
    return sel ? when1 : when0;
  endfunction

  // Counts the ones among five bits. Used by the assertions.
  function automatic int ones5(input logic a, input logic b, input logic c,
                               input logic d, input logic e);
    return int'(a) + int'(b) + int'(c) + int'(d) + int'(e);
  endfunction

endpackage

// File: rtl/cmp42_cell.sv
module cmp42_cell
  import cmp42_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic cin,
  output logic s,
  output logic cy,
  output logic co
);
  logic ab_x;   // XOR level 1
  logic cd_x;   // XOR level 1
  logic quad_x; // XOR level 2: parity of a, b, c, d

  always_comb begin
    ab_x   = a ^ b;
    cd_x   = c ^ d;
    quad_x = ab_x ^ cd_x;
    s      = quad_x ^ cin;              // XOR level 3
    co     = maj3(a, b, c);             // independent of cin
    cy     = pick(quad_x, cin, d);
  end

  always_comb begin
    // R6
    cell_count_chk: assert (ones5(a, b, c, d, cin) == int'(s) + 2 * (int'(cy) + int'(co)))
      else $error("cell count mismatch");
    // R5
    if (a & b & c) begin
      side_high_chk: assert (co) else $error("side carry should be 1");
    end
    // R5
    if (!(a | b | c)) begin
      side_low_chk: assert (!co) else $error("side carry should be 0");
    end
  end

endmodule

// File: rtl/cmp42_pack.sv
module cmp42_pack #(
  parameter int W = 16
) (
  input  logic [W-1:0] sbits_i,
  input  logic [W-1:0] cbits_i,
  input  logic         top_side_i,
  output logic [W+1:0] sum_o,
  output logic [W+1:0] carry_o
);
  always_comb begin
    sum_o   = {1'b0, top_side_i, sbits_i};
    carry_o = {1'b0, cbits_i, 1'b0};
  end
endmodule

// File: rtl/cmp42_reduce.sv
module cmp42_reduce #(
  parameter int W = 16
) (
  input  logic [W-1:0] row0_i,
  input  logic [W-1:0] row1_i,
  input  logic [W-1:0] row2_i,
  input  logic [W-1:0] row3_i,
  output logic [W+1:0] sum_o,
  output logic [W+1:0] carry_o
);
  localparam int OW = W + 2;

  logic [W:0]   side_chain;
  logic [W-1:0] sbits;
  logic [W-1:0] cbits;

  assign side_chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    cmp42_cell u_cell (
      .a   (row0_i[i]),
      .b   (row1_i[i]),
      .c   (row2_i[i]),
      .d   (row3_i[i]),
      .cin (side_chain[i]),
      .s   (sbits[i]),
      .cy  (cbits[i]),
      .co  (side_chain[i+1])
    );
  end

  cmp42_pack #(.W(W)) u_pack (
    .sbits_i    (sbits),
    .cbits_i    (cbits),
    .top_side_i (side_chain[W]),
    .sum_o      (sum_o),
    .carry_o    (carry_o)
  );

  logic [OW-1:0] in_total;
  logic [OW-1:0] out_total;

  always_comb begin
    in_total  = OW'(row0_i) + OW'(row1_i) + OW'(row2_i) + OW'(row3_i);
    out_total = sum_o + carry_o;
    // R1
    row_total_chk: assert (in_total == out_total) else $error("row total changed");
    // R2
    carry_lsb_chk: assert (!carry_o[0]) else $error("carry lsb set");
    // R3
    sum_msb_chk: assert (!sum_o[OW-1]) else $error("sum msb set");
  end

endmodule

// File: tb/cmp42_reduce_test.sv
module cmp42_reduce_test;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [W-1:0] r0, r1, r2, r3;
  logic [W+1:0] so, co;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cmp42_reduce #(.W(W)) uut (
    .row0_i(r0), .row1_i(r1), .row2_i(r2), .row3_i(r3),
    .sum_o(so), .carry_o(co)
  );

  // Per-bit counting model, written from the requirements
  function automatic void model(input logic [W-1:0] a, b, c, d,
                                output logic [W+1:0] es, ec);
    int lin = 0;
    es = '0;
    ec = '0;
    for (int i = 0; i < W; i++) begin
      int n3 = int'(a[i]) + int'(b[i]) + int'(c[i]);
      int n5 = n3 + int'(d[i]) + lin;
      int lo = (n3 >= 2) ? 1 : 0;
      int sb = n5 % 2;
      int cb = (n5 - sb) / 2 - lo;
      es[i]   = (sb == 1);
      ec[i+1] = (cb == 1);
      lin     = lo;
    end
    es[W] = (lin == 1);
  endfunction

  task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_and_check(input logic [W-1:0] a, b, c, d);
    logic [W+1:0] es, ec, tot;
    @(posedge clk);
    r0 = a; r1 = b; r2 = c; r3 = d;
    @(negedge clk);
    model(a, b, c, d, es, ec);
    tot = (W+2)'(a) + (W+2)'(b) + (W+2)'(c) + (W+2)'(d);
    chk("R1", so + co, tot);
    chk("R2", (W+2)'(co[0]), '0);
    chk("R3", (W+2)'(so[W+1]), '0);
    chk("R4", (W+2)'(so[W-1:0]), (W+2)'(es[W-1:0]));
    chk("R5", (W+2)'(so[W]), (W+2)'(es[W]));
    chk("R6", co, ec);
  endtask

  initial begin
    r0 = '0; r1 = '0; r2 = '0; r3 = '0;
    void'($urandom(32'd20240611));
    // R8: zero rows
    apply_and_check('0, '0, '0, '0);
    chk("R8", so, '0);
    chk("R8", co, '0);
    // R7: all ones
    apply_and_check('1, '1, '1, '1);
    chk("R7", so, 18'h1FFFE);
    chk("R7", co, 18'h1FFFE);
    // R5: side carry set by row0/row1, row3 has no effect on it
    apply_and_check('1, '1, '0, '0);
    chk("R5", (W+2)'(so[W]), (W+2)'(1));
    apply_and_check('1, '1, '0, '1);
    chk("R5", (W+2)'(so[W]), (W+2)'(1));
    // R5: row3 alone never raises the side carry
    apply_and_check('0, '0, '0, '1);
    chk("R5", (W+2)'(so[W]), '0);
    chk("R6", co, '0);
    // R4: alternating patterns
    apply_and_check(16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555);
    apply_and_check(16'h8000, 16'h8000, 16'h8000, 16'h8000);
    // random
    for (int k = 0; k < 300; k++) begin
      apply_and_check(W'($urandom), W'($urandom), W'($urandom), W'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule